// File: doc/BRIEF.md
# Zone Protection Checker

This block settles the final access rights for an address translation that has already hit in the TLB. It takes the data word of the matching entry, the 32-bit zone protection register, the current privilege level and the write and execute bits held in the entry, and from these it produces read, write and execute grants and a protection-error flag. The entry's zone select picks one 2-bit field out of the zone protection register. The field's code then keeps the page's own bits, widens them to full rights, or denies a user-mode access outright.

Two parameters fix the MMU configuration. When the mode parameter equals 1, zones are disabled and every lookup uses the page bits. A zone count parameter sets the highest valid zone select. A select above that count is treated as "use page bits" and is flagged on a one-cycle out-of-range output. The datapath is combinational. A third parameter can add one register stage on the outputs, which resets asynchronously.

Top module: `zprot_check`

## Requirements
- R1: The zone select is bits [7:4] of `tlb_data`. Its 2-bit zone code for select z is `zpr[31-2z:30-2z]`, so zone 0 is `zpr[31:30]` and zone 15 is `zpr[1:0]`.
- R2: When `hit_valid` is 1 and the zone select is greater than `ZONE_CNT`, the zone code used is 1 and `zone_oor` is 1. Otherwise `zone_oor` is 0.
- R3: When `MODE_CFG` equals 1, the zone code used is always 1, whatever `zpr` holds.
- R4: Code 0 with `user_mode`=1 denies the access: `grant_rd`, `grant_wr` and `grant_ex` are 0 and `prot_err` is 1.
- R5: Code 1, and code 0 with `user_mode`=0, give `grant_rd`=1, `grant_wr`=`page_wr`, `grant_ex`=`page_ex` and `prot_err`=0.
- R6: Code 2 acts as code 1 when `user_mode`=1 and as code 3 when `user_mode`=0.
- R7: Code 3 gives `grant_rd`, `grant_wr` and `grant_ex` all 1 and `prot_err`=0.
- R8: With `REG_OUT`=1, every output shows the inputs of the previous clock edge, and all outputs are 0 while `rst_n` is low. With `REG_OUT`=0, the outputs follow the inputs in the same cycle.
- R9: When `hit_valid` is 0, `rights_valid`, the grants, `prot_err` and `zone_oor` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | A TLB hit is presented this cycle |
| tlb_data | input | 32 | Data word of the matching entry; zone select in [7:4] |
| zpr | input | 32 | Zone protection register, 2 bits per zone |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| page_wr | input | 1 | Write bit stored in the entry |
| page_ex | input | 1 | Execute bit stored in the entry |
| rights_valid | output | 1 | Outputs belong to a valid hit |
| grant_rd | output | 1 | Read permitted |
| grant_wr | output | 1 | Write permitted |
| grant_ex | output | 1 | Execute permitted |
| prot_err | output | 1 | Access denied by zone protection |
| zone_oor | output | 1 | Zone select exceeded the configured count |

## Verification
The bench builds two copies of the block. The first uses `MODE_CFG`=3, `ZONE_CNT`=9 and `REG_OUT`=1. A count below 15 lets selects 10 through 15 reach the out-of-range path, and the register stage brings the reset and latency behaviour into reach. The second uses `MODE_CFG`=1, `ZONE_CNT`=16 and `REG_OUT`=0, which exercises the zones-disabled override and the same-cycle combinational path. Both copies are swept over every zone select, zone code, privilege level and pair of page bits. Every other zone field is filled with a different code, so a wrong field selection shows up in the grants.

// File: rtl/zprot_pkg.sv
package zprot_pkg;

  typedef enum logic [1:0] {
    ZC_USER_DENY  = 2'd0,
    ZC_PAGE       = 2'd1,
    ZC_SUPER_FULL = 2'd2,
    ZC_FULL       = 2'd3
  } zone_code_e;

  typedef struct packed {
    logic valid;
    logic rd;
    logic wr;
    logic ex;
    logic perr;
    logic oor;
  } rights_t;

endpackage

// File: rtl/zprot_zone_select.sv
module zprot_zone_select
  import zprot_pkg::*;
#(
  parameter int MODE_CFG = 3,
  parameter int ZONE_CNT = 16,
  parameter int SEL_LSB  = 4,
  parameter int SEL_W    = 4,
  parameter int REG_W    = 32
) (
  input  logic             hit_valid,
  input  logic [SEL_W-1:0] zone_sel,
  input  logic [REG_W-1:0] zpr,
  output zone_code_e       zone_code,
  output logic             sel_oor
);

  localparam int            FIELD_W = 2;
  localparam int            SH_W    = $clog2(REG_W) + 1;
  localparam logic [SH_W-1:0] TOP_SH = SH_W'(REG_W - FIELD_W);
  localparam logic [SEL_W:0]  LIMIT  = (SEL_W+1)'(ZONE_CNT);

  logic [SH_W-1:0]  shift_amt;
  logic [REG_W-1:0] shifted;
  logic [FIELD_W-1:0] raw_field;
  logic             beyond;

  always_comb begin
    shift_amt = TOP_SH - SH_W'({zone_sel, 1'b0});
    shifted   = zpr >> shift_amt;
    raw_field = shifted[FIELD_W-1:0];
    beyond    = ({1'b0, zone_sel} > LIMIT);
  end

  generate
    if (MODE_CFG == 1) begin : g_zones_off
      assign zone_code = ZC_PAGE;
    end else begin : g_zones_on
      assign zone_code = beyond ? ZC_PAGE : zone_code_e'(raw_field);
    end
  endgenerate

  assign sel_oor = hit_valid & beyond;

  logic unused_sel;
  assign unused_sel = ^SEL_LSB;

endmodule

// File: rtl/zprot_rights_eval.sv
module zprot_rights_eval
  import zprot_pkg::*;
(
  input  logic       hit_valid,
  input  zone_code_e zone_code,
  input  logic       user_mode,
  input  logic       page_wr,
  input  logic       page_ex,
  output logic       grant_rd,
  output logic       grant_wr,
  output logic       grant_ex,
  output logic       denied
);

  logic rd_v, wr_v, ex_v, deny_v;

  always_comb begin
    rd_v   = 1'b1;
    wr_v   = page_wr;
    ex_v   = page_ex;
    deny_v = 1'b0;
    unique case (zone_code)
      ZC_USER_DENY: begin
        if (user_mode) begin
          deny_v = 1'b1;
          rd_v   = 1'b0;
          wr_v   = 1'b0;
          ex_v   = 1'b0;
        end
      end
      ZC_PAGE: ;
      ZC_SUPER_FULL: begin
        if (!user_mode) begin
          wr_v = 1'b1;
          ex_v = 1'b1;
        end
      end
      ZC_FULL: begin
        wr_v = 1'b1;
        ex_v = 1'b1;
      end
      default: ;
    endcase
    grant_rd = hit_valid & rd_v;
    grant_wr = hit_valid & wr_v;
    grant_ex = hit_valid & ex_v;
    denied   = hit_valid & deny_v;
  end

endmodule

// File: rtl/zprot_check.sv
module zprot_check
  import zprot_pkg::*;
#(
  parameter int MODE_CFG = 3,
  parameter int ZONE_CNT = 16,
  parameter int REG_OUT  = 1,
  parameter int DATA_W   = 32,
  parameter int ZPR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [DATA_W-1:0] tlb_data,
  input  logic [ZPR_W-1:0]  zpr,
  input  logic              user_mode,
  input  logic              page_wr,
  input  logic              page_ex,
  output logic              rights_valid,
  output logic              grant_rd,
  output logic              grant_wr,
  output logic              grant_ex,
  output logic              prot_err,
  output logic              zone_oor
);

  localparam int SEL_LSB = 4;
  localparam int SEL_W   = 4;
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

  zone_code_e code_w;
  rights_t    comb_r;
  rights_t    out_r;

  zprot_zone_select #(
    .MODE_CFG (MODE_CFG),
    .ZONE_CNT (ZONE_CNT),
    .SEL_LSB  (SEL_LSB),
    .SEL_W    (SEL_W),
    .REG_W    (ZPR_W)
  ) zsel_i (
    .hit_valid (hit_valid),
    .zone_sel  (tlb_data[SEL_MSB:SEL_LSB]),
    .zpr       (zpr),
    .zone_code (code_w),
    .sel_oor   (comb_r.oor)
  );

  zprot_rights_eval eval_i (
    .hit_valid (hit_valid),
    .zone_code (code_w),
    .user_mode (user_mode),
    .page_wr   (page_wr),
    .page_ex   (page_ex),
    .grant_rd  (comb_r.rd),
    .grant_wr  (comb_r.wr),
    .grant_ex  (comb_r.ex),
    .denied    (comb_r.perr)
  );

  assign comb_r.valid = hit_valid;

  generate
    if (REG_OUT != 0) begin : g_reg
      rights_t out_d;
      rights_t out_q;
      logic    out_en;

      always_comb begin
        out_en = 1'b1;
        out_d  = out_q;
        if (out_en) out_d = comb_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
      end

      assign out_r = out_q;

      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
      end

      // R8
      reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (out_q == $past(comb_r)));
    end else begin : g_comb
      assign out_r = comb_r;
    end
  endgenerate

  assign rights_valid = out_r.valid;
  assign grant_rd     = out_r.rd;
  assign grant_wr     = out_r.wr;
  assign grant_ex     = out_r.ex;
  assign prot_err     = out_r.perr;
  assign zone_oor     = out_r.oor;

  logic unused_data;
  assign unused_data = ^{tlb_data[DATA_W-1:SEL_MSB+1], tlb_data[SEL_LSB-1:0]};

  // R4
  deny_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_r.perr |-> (!comb_r.rd && !comb_r.wr && !comb_r.ex));

  // R5
  super_keeps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !user_mode && page_wr) |-> comb_r.wr);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (!comb_r.rd && !comb_r.wr && !comb_r.ex && !comb_r.perr && !comb_r.oor));

  // R2
  oor_uses_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_r.oor |-> (code_w == ZC_PAGE && !comb_r.perr && comb_r.rd));

endmodule

// File: tb/zprot_check_tb.sv
`timescale 1ns/1ps
module zprot_check_tb_top;

  localparam int A_MODE = 3;
  localparam int A_ZCNT = 9;
  localparam int B_MODE = 1;
  localparam int B_ZCNT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        hit_valid = 1'b0;
  logic [31:0] tlb_data  = '0;
  logic [31:0] zpr       = '0;
  logic        user_mode = 1'b0;
  logic        page_wr   = 1'b0;
  logic        page_ex   = 1'b0;

  logic a_v, a_rd, a_wr, a_ex, a_pe, a_oor;
  logic b_v, b_rd, b_wr, b_ex, b_pe, b_oor;

  zprot_check #(.MODE_CFG(A_MODE), .ZONE_CNT(A_ZCNT), .REG_OUT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .tlb_data(tlb_data),
    .zpr(zpr), .user_mode(user_mode), .page_wr(page_wr), .page_ex(page_ex),
    .rights_valid(a_v), .grant_rd(a_rd), .grant_wr(a_wr), .grant_ex(a_ex),
    .prot_err(a_pe), .zone_oor(a_oor));

  zprot_check #(.MODE_CFG(B_MODE), .ZONE_CNT(B_ZCNT), .REG_OUT(0)) dut_nz_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .tlb_data(tlb_data),
    .zpr(zpr), .user_mode(user_mode), .page_wr(page_wr), .page_ex(page_ex),
    .rights_valid(b_v), .grant_rd(b_rd), .grant_wr(b_wr), .grant_ex(b_ex),
    .prot_err(b_pe), .zone_oor(b_oor));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected {valid, rd, wr, ex, perr, oor} from R1..R9.
  function automatic logic [5:0] model(input logic v, input int zs, input int field,
                                       input logic usr, input logic pw, input logic pe,
                                       input int mode, input int zcnt);
    int code;
    logic rd, wr, ex, perr, oor;
    oor  = v && (zs > zcnt);
    code = field;
    if (zs > zcnt) code = 1;
    if (mode == 1) code = 1;
    rd = 1; wr = pw; ex = pe; perr = 0;
    if (code == 0 && usr) begin rd = 0; wr = 0; ex = 0; perr = 1; end
    if (code == 3 || (code == 2 && !usr)) begin wr = 1; ex = 1; end
    if (!v) begin rd = 0; wr = 0; ex = 0; perr = 0; end
    return {v, rd, wr, ex, perr, oor};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (valid rd wr ex perr oor)", req, act, exp);
    end
  endtask

  function automatic string tag_for(input int zs, input int field, input logic usr,
                                    input int mode, input int zcnt);
    if (mode == 1) return "R3";
    if (zs > zcnt) return "R2";
    case (field)
      0: return usr ? "R4" : "R5";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Zone z gets code f; every other zone gets 3-f (R1 field placement).
  function automatic logic [31:0] make_zpr(input int z, input int f);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] val;
      val = (k == z) ? f[1:0] : 2'(3 - f);
      r[31-2*k -: 2] = val;
    end
    return r;
  endfunction

  task automatic run_vec(input logic v, input int zs, input int f,
                         input logic usr, input logic pw, input logic pe);
    logic [5:0] ea, eb;
    @(negedge clk);
    hit_valid = v;
    tlb_data  = {20'hABCDE, 4'h5, zs[3:0], 4'hA};
    zpr       = make_zpr(zs, f);
    user_mode = usr;
    page_wr   = pw;
    page_ex   = pe;
    ea = model(v, zs, f, usr, pw, pe, A_MODE, A_ZCNT);
    eb = model(v, zs, f, usr, pw, pe, B_MODE, B_ZCNT);
    #1;
    check(v ? {"R8 comb ", tag_for(zs, f, usr, B_MODE, B_ZCNT)} : "R9",
          {b_v, b_rd, b_wr, b_ex, b_pe, b_oor}, eb);
    @(negedge clk);
    check(v ? {"R1 ", tag_for(zs, f, usr, A_MODE, A_ZCNT)} : "R9",
          {a_v, a_rd, a_wr, a_ex, a_pe, a_oor}, ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hit_valid = 1'b1;
    user_mode = 1'b0;
    zpr       = '1;
    #1;
    // R8: registered outputs held at zero during reset
    check("R8 reset", {a_v, a_rd, a_wr, a_ex, a_pe, a_oor}, 6'b0);
    @(negedge clk);
    hit_valid = 1'b0;
    rst_n = 1'b1;
    for (int zs = 0; zs < 16; zs++)
      for (int f = 0; f < 4; f++)
        for (int u = 0; u < 2; u++)
          for (int p = 0; p < 4; p++)
            run_vec(1'b1, zs, f, u[0], p[1], p[0]);
    // R9: no hit, even with deny and out-of-range stimulus
    run_vec(1'b0, 2, 0, 1'b1, 1'b1, 1'b1);
    run_vec(1'b0, 12, 3, 1'b0, 1'b1, 1'b1);
    run_vec(1'b0, 7, 2, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule